// File: doc/BRIEF.md
# ECC-protected register file with fault injector

This block is a small general-purpose register file. Each word is kept with a SECDED code: a write encodes the word, and each of the two read ports checks the stored word and corrects it on the way out. A control register can arm a deliberate fault. While the fault is armed, every register write stores its data with one or two bits flipped, so the check logic, the error reporting and the handler that follows can be exercised on demand.

An error found by an enabled read is reported on a registered two-bit severity code and a four-bit origin code. An uncorrectable error also requests action from the surrounding core. With the default build it raises a stall request that holds until reset. With `TRAP_ON_ECC` set it raises a one-cycle trap request that carries a fixed cause code. Disarming the injector only needs a zero written to the enable bit.

Top module: `ecc_regfile_inj`

## Requirements
- R1: The injection register reads back its enable in bit 31 and its fault selector in bits 3:0. Bits 30:4 always read zero. Reset clears the whole register.
- R2: A register written without an armed fault returns the written word on either read port, and the read reports no error.
- R3: While enable=1 and selector=0, each register write flips stored data bit 0. A later read returns the original word, sets status 2'b01 and source 4'b0001, and raises neither stall nor trap.
- R4: While enable=1 and selector=1, each register write flips stored data bits 0 and 1. A later read returns the stored word unchanged (bits 0 and 1 still inverted) and sets status 2'b11 and source 4'b0001.
- R5: With enable=0, or with a selector other than 0 or 1, writes are stored intact and reads report no new error.
- R6: Status and source are registered. They change on the clock edge that ends the erroring read, and otherwise hold their value. Reset sets them to 2'b00 and 4'b0000, clears every register to zero and drops the stall.
- R7: Register 0 always reads zero, ignores writes and never reports an error.
- R8: With TRAP_ON_ECC=0, an uncorrectable read raises stall_req from the next cycle and keeps it high until reset. trap_req stays low.
- R9: With TRAP_ON_ECC=1, an uncorrectable read raises trap_req for exactly one cycle, with trap_cause equal to ECC_CAUSE. stall_req stays low.
- R10: When both ports find errors in the same cycle, the uncorrectable result wins, giving status 2'b11.
- R11: A read port whose enable is low reports nothing, even if the word it addresses is corrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_we | input | 1 | Write strobe for the injection register |
| csr_wdata | input | 32 | Injection register write data |
| csr_rdata | output | 32 | Injection register read data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | AW | Register write index |
| wr_data | input | 32 | Register write data |
| rd0_en | input | 1 | Read port 0 enable (arms error reporting) |
| rd0_addr | input | AW | Read port 0 index |
| rd0_data | output | 32 | Read port 0 corrected data |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_addr | input | AW | Read port 1 index |
| rd1_data | output | 32 | Read port 1 corrected data |
| ecc_status | output | 2 | Last error severity: 00 none, 01 corrected, 11 uncorrectable |
| ecc_source | output | 4 | Last error origin, 0001 for this register file |
| stall_req | output | 1 | Sticky hold request after an uncorrectable error |
| trap_req | output | 1 | One-cycle trap request after an uncorrectable error |
| trap_cause | output | CAUSE_W | Cause code, valid while trap_req is high |

## Verification
The assertions assume that every fault comes from the injector. Real storage does not upset itself, so a single-bit or double-bit detection is always the result of an armed write. The stimulus therefore changes stored words only through the write port, and it disarms the injector before each read. The assertions also assume that a read and a write never target the same register in the same cycle, and the stimulus never issues both. Read indices stay within the register count.

// File: rtl/ecc_rf_pkg.sv
`timescale 1ns/1ps
package ecc_rf_pkg;
  localparam int DW   = 32;
  localparam int HW   = 6;
  localparam int CW   = HW + 1;
  localparam int NPOS = DW + HW;

  typedef enum logic [1:0] {
    ECC_OK    = 2'b00,
    ECC_FIXED = 2'b01,
    ECC_FATAL = 2'b11
  } ecc_stat_e;

  localparam logic [3:0] SRC_NONE = 4'b0000;
  localparam logic [3:0] SRC_GPR  = 4'b0001;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          sgl;
    logic          dbl;
  } ecc_rd_t;

  // Hamming check bits plus overall parity in the top bit
  function automatic logic [CW-1:0] ecc_encode(input logic [DW-1:0] d);
    logic [HW-1:0] h;
    int k;
    h = '0;
    k = 0;
    for (int p = 1; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (k < DW && d[k]) h = h ^ HW'(p);
        k++;
      end
    end
    return {(^d) ^ (^h), h};
  endfunction

  function automatic ecc_rd_t ecc_decode(input logic [DW-1:0] d, input logic [CW-1:0] c);
    ecc_rd_t r;
    logic [CW-1:0] fresh;
    logic [HW-1:0] syn;
    logic odd;
    int k;
    fresh = ecc_encode(d);
    syn   = fresh[HW-1:0] ^ c[HW-1:0];
    odd   = (^d) ^ (^c);
    r.data = d;
    r.sgl  = odd;
    r.dbl  = !odd && (syn != '0);
    k = 0;
    for (int p = 1; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (k < DW && odd && syn == HW'(p)) r.data[k] = ~d[k];
        k++;
      end
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] inj_mask(input logic en, input logic [3:0] sel);
    if (!en)          return '0;
    else if (sel == 4'd0) return DW'(32'h1);
    else if (sel == 4'd1) return DW'(32'h3);
    else              return '0;
  endfunction
endpackage

// File: rtl/ecc_rf_injctl.sv
`timescale 1ns/1ps
module ecc_rf_injctl
  import ecc_rf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_we,
  input  logic [31:0]   csr_wdata,
  output logic [31:0]   csr_rdata,
  output logic [DW-1:0] flip_mask
);
  logic       arm_q;
  logic [3:0] sel_q;
  logic       unused_csr_bits;

  assign unused_csr_bits = ^csr_wdata[30:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      sel_q <= 4'd0;
    end else if (csr_we) begin
      arm_q <= csr_wdata[31];
      sel_q <= csr_wdata[3:0];
    end
  end

  assign csr_rdata = {arm_q, 27'd0, sel_q};
  assign flip_mask = inj_mask(arm_q, sel_q);
endmodule

// File: rtl/ecc_rf_bank.sv
`timescale 1ns/1ps
module ecc_rf_bank
  import ecc_rf_pkg::*;
#(
  parameter int NREG = 32,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [DW-1:0]           flip_mask,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rword,
  output logic [NRD-1:0][CW-1:0]  rchk
);
  logic [DW-1:0] mem_d [NREG];
  logic [CW-1:0] mem_c [NREG];
  logic          wr_live;

  assign wr_live = we && (waddr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        mem_d[i] <= '0;
        mem_c[i] <= '0;
      end
    end else if (wr_live) begin
      mem_d[waddr] <= wdata ^ flip_mask;
      mem_c[waddr] <= ecc_encode(wdata);
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rword[g] = mem_d[raddr[g]];
    assign rchk[g]  = mem_c[raddr[g]];
  end
endmodule

// File: rtl/ecc_rf_rdport.sv
`timescale 1ns/1ps
module ecc_rf_rdport
  import ecc_rf_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] word,
  input  logic [CW-1:0] chk,
  output logic [DW-1:0] data,
  output logic          sgl,
  output logic          dbl
);
  ecc_rd_t res;
  logic    zero_reg;

  assign zero_reg = (addr == '0);
  assign res      = ecc_decode(word, chk);
  assign data     = zero_reg ? '0 : res.data;
  assign sgl      = en && !zero_reg && res.sgl;
  assign dbl      = en && !zero_reg && res.dbl;
endmodule

// File: rtl/ecc_regfile_inj.sv
`timescale 1ns/1ps
module ecc_regfile_inj
  import ecc_rf_pkg::*;
#(
  parameter int              NREG        = 32,
  parameter bit              TRAP_ON_ECC = 1'b0,
  parameter int              CAUSE_W     = 6,
  parameter logic [CAUSE_W-1:0] ECC_CAUSE = 6'd24,
  localparam int             AW          = $clog2(NREG),
  localparam int             NRD         = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_we,
  input  logic [31:0]        csr_wdata,
  output logic [31:0]        csr_rdata,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               rd0_en,
  input  logic [AW-1:0]      rd0_addr,
  output logic [31:0]        rd0_data,
  input  logic               rd1_en,
  input  logic [AW-1:0]      rd1_addr,
  output logic [31:0]        rd1_data,
  output logic [1:0]         ecc_status,
  output logic [3:0]         ecc_source,
  output logic               stall_req,
  output logic               trap_req,
  output logic [CAUSE_W-1:0] trap_cause
);
  logic [DW-1:0]           flip_mask;
  logic [NRD-1:0][AW-1:0]  rp_addr;
  logic [NRD-1:0]          rp_en;
  logic [NRD-1:0][DW-1:0]  rp_word;
  logic [NRD-1:0][CW-1:0]  rp_chk;
  logic [NRD-1:0][DW-1:0]  rp_data;
  logic [NRD-1:0]          rp_sgl;
  logic [NRD-1:0]          rp_dbl;

  // named events for the checker
  logic det_sgl;
  logic det_dbl;

  ecc_stat_e  stat_q;
  logic [3:0] src_q;
  logic       stall_q;
  logic       trap_q;

  ecc_rf_injctl u_inj (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .flip_mask (flip_mask)
  );

  assign rp_addr = {rd1_addr, rd0_addr};
  assign rp_en   = {rd1_en, rd0_en};

  ecc_rf_bank #(.NREG(NREG), .NRD(NRD)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (wr_en),
    .waddr     (wr_addr),
    .wdata     (wr_data),
    .flip_mask (flip_mask),
    .raddr     (rp_addr),
    .rword     (rp_word),
    .rchk      (rp_chk)
  );

  for (genvar g = 0; g < NRD; g++) begin : g_port
    ecc_rf_rdport #(.AW(AW)) u_port (
      .en   (rp_en[g]),
      .addr (rp_addr[g]),
      .word (rp_word[g]),
      .chk  (rp_chk[g]),
      .data (rp_data[g]),
      .sgl  (rp_sgl[g]),
      .dbl  (rp_dbl[g])
    );
  end

  assign rd0_data = rp_data[0];
  assign rd1_data = rp_data[1];
  assign det_sgl  = |rp_sgl;
  assign det_dbl  = |rp_dbl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= ECC_OK;
      src_q   <= SRC_NONE;
      stall_q <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      trap_q <= 1'b0;
      if (det_dbl) begin
        stat_q <= ECC_FATAL;
        src_q  <= SRC_GPR;
        if (TRAP_ON_ECC) trap_q  <= 1'b1;
        else             stall_q <= 1'b1;
      end else if (det_sgl) begin
        stat_q <= ECC_FIXED;
        src_q  <= SRC_GPR;
      end
    end
  end

  assign ecc_status = stat_q;
  assign ecc_source = src_q;
  assign stall_req  = stall_q;
  assign trap_req   = trap_q;
  assign trap_cause = trap_q ? ECC_CAUSE : '0;
endmodule

// File: rtl/ecc_rf_sva.sv
`timescale 1ns/1ps
module ecc_rf_sva #(
  parameter int              AW          = 5,
  parameter bit              TRAP_ON_ECC = 1'b0,
  parameter int              CAUSE_W     = 6,
  parameter logic [CAUSE_W-1:0] ECC_CAUSE = 6'd24
) (
  input logic               clk,
  input logic               rst_n,
  input logic [31:0]        csr_rdata,
  input logic               rd0_en,
  input logic [AW-1:0]      rd0_addr,
  input logic [31:0]        rd0_data,
  input logic               rd1_en,
  input logic [AW-1:0]      rd1_addr,
  input logic [31:0]        rd1_data,
  input logic               det_sgl,
  input logic               det_dbl,
  input logic [1:0]         ecc_status,
  input logic [3:0]         ecc_source,
  input logic               stall_req,
  input logic               trap_req,
  input logic [CAUSE_W-1:0] trap_cause
);
  p_csr_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[30:4] == 27'd0);

  p_x0_port0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_addr == '0) |-> (rd0_data == 32'd0));

  p_x0_port1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_addr == '0) |-> (rd1_data == 32'd0));

  p_fixed_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (det_sgl && !det_dbl) |=> (ecc_status == 2'b01 && ecc_source == 4'b0001));

  p_fatal_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    det_dbl |=> (ecc_status == 2'b11 && ecc_source == 4'b0001));

  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_sgl && !det_dbl) |=> ($stable(ecc_status) && $stable(ecc_source)));

  p_status_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_status != 2'b10);

  p_stall_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!TRAP_ON_ECC && det_dbl) |=> stall_req);

  p_stall_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |=> stall_req);

  p_trap_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (TRAP_ON_ECC && det_dbl) |=> (trap_req && trap_cause == ECC_CAUSE));

  p_trap_only_after_fatal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_req) |-> $past(det_dbl));

  p_one_request_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall_req && trap_req));

  p_fixed_no_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (det_sgl && !det_dbl && !stall_req) |=> (!stall_req && !trap_req));

  p_idle_ports_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd0_en && !rd1_en) |-> (!det_sgl && !det_dbl));
endmodule

bind ecc_regfile_inj ecc_rf_sva #(
  .AW          (AW),
  .TRAP_ON_ECC (TRAP_ON_ECC),
  .CAUSE_W     (CAUSE_W),
  .ECC_CAUSE   (ECC_CAUSE)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .csr_rdata  (csr_rdata),
  .rd0_en     (rd0_en),
  .rd0_addr   (rd0_addr),
  .rd0_data   (rd0_data),
  .rd1_en     (rd1_en),
  .rd1_addr   (rd1_addr),
  .rd1_data   (rd1_data),
  .det_sgl    (det_sgl),
  .det_dbl    (det_dbl),
  .ecc_status (ecc_status),
  .ecc_source (ecc_source),
  .stall_req  (stall_req),
  .trap_req   (trap_req),
  .trap_cause (trap_cause)
);

// File: tb/ecc_regfile_inj_test.sv
`timescale 1ns/1ps
module ecc_regfile_inj_test;
  localparam int AW = 5;
  localparam logic [5:0] CAUSE = 6'd24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic        wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd0_en = 1'b0;
  logic [AW-1:0] rd0_addr = '0;
  logic        rd1_en = 1'b0;
  logic [AW-1:0] rd1_addr = '0;

  logic [31:0] csr_rdata, rd0_data, rd1_data;
  logic [1:0]  ecc_status;
  logic [3:0]  ecc_source;
  logic        stall_req, trap_req;
  logic [5:0]  trap_cause;

  logic [31:0] t_csr_rdata, t_rd0_data, t_rd1_data;
  logic [1:0]  t_status;
  logic [3:0]  t_source;
  logic        t_stall, t_trap;
  logic [5:0]  t_cause;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ecc_regfile_inj #(.NREG(32), .TRAP_ON_ECC(1'b0), .CAUSE_W(6), .ECC_CAUSE(CAUSE)) uut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .ecc_status(ecc_status), .ecc_source(ecc_source),
    .stall_req(stall_req), .trap_req(trap_req), .trap_cause(trap_cause));

  ecc_regfile_inj #(.NREG(32), .TRAP_ON_ECC(1'b1), .CAUSE_W(6), .ECC_CAUSE(CAUSE)) uut_trap (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(t_csr_rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd0_data(t_rd0_data),
    .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_data(t_rd1_data),
    .ecc_status(t_status), .ecc_source(t_source),
    .stall_req(t_stall), .trap_req(t_trap), .trap_cause(t_cause));

  // {enable, selector, register, data, expected status after the read}
  localparam logic [43:0] VEC [6] = '{
    {1'b0, 4'd0, 5'd1, 32'hA5A5_5A5A, 2'b00},
    {1'b1, 4'd0, 5'd2, 32'h1234_5678, 2'b01},
    {1'b1, 4'd5, 5'd3, 32'hFFFF_0000, 2'b01},
    {1'b0, 4'd1, 5'd4, 32'h0F0F_F0F0, 2'b01},
    {1'b1, 4'd1, 5'd5, 32'hDEAD_BEEF, 2'b11},
    {1'b1, 4'd0, 5'd6, 32'h8000_0001, 2'b01}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_put(input logic [31:0] v);
    csr_we = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic reg_put(input logic [AW-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fin();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    fin();
  end

  initial begin
    logic [1:0] es;
    logic [31:0] ed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R1, R6)
    chk(csr_rdata == 32'd0, "R1 reset csr", csr_rdata, 32'd0);
    chk(ecc_status == 2'b00 && ecc_source == 4'd0, "R6 reset status", {26'd0, ecc_status, ecc_source}, 32'd0);
    chk(!stall_req && !trap_req && !t_trap, "R8 reset requests", {29'd0, stall_req, trap_req, t_trap}, 32'd0);

    // vector table: arm, write, disarm, read on port 0
    for (int i = 0; i < 6; i++) begin
      es = VEC[i][1:0];
      ed = (es == 2'b11 && VEC[i][43] && VEC[i][42:39] == 4'd1) ? (VEC[i][33:2] ^ 32'h3) : VEC[i][33:2];
      csr_put({VEC[i][43], 27'd0, VEC[i][42:39]});
      reg_put(VEC[i][38:34], VEC[i][33:2]);
      csr_put(32'd0);
      rd0_en = 1'b1; rd0_addr = VEC[i][38:34];
      #1;
      chk(rd0_data == ed, "R2 R3 R4 R5 read data", rd0_data, ed);
      @(negedge clk);
      rd0_en = 1'b0;
      chk(ecc_status == es, "R3 R4 R5 R6 status", {30'd0, ecc_status}, {30'd0, es});
      chk(ecc_source == ((i == 0) ? 4'd0 : 4'd1), "R3 R4 source", {28'd0, ecc_source}, (i == 0) ? 32'd0 : 32'd1);
      chk(stall_req == (i >= 4) && !trap_req, "R8 stall", {30'd0, stall_req, trap_req}, (i >= 4) ? 32'd2 : 32'd0);
      chk(t_trap == (i == 4) && !t_stall, "R9 trap pulse", {30'd0, t_stall, t_trap}, (i == 4) ? 32'd1 : 32'd0);
      if (i == 4) chk(t_cause == CAUSE, "R9 cause", {26'd0, t_cause}, {26'd0, CAUSE});
    end

    // R1 reserved bits read as zero
    csr_put(32'hFFFF_FFF3);
    chk(csr_rdata == 32'h8000_0003, "R1 csr layout", csr_rdata, 32'h8000_0003);
    csr_put(32'd0);

    // R7 register 0 ignores writes, even corrupted ones, and never reports
    csr_put(32'h8000_0001);
    reg_put(5'd0, 32'hCAFE_F00D);
    csr_put(32'd0);
    rd1_en = 1'b1; rd1_addr = 5'd0;
    #1;
    chk(rd1_data == 32'd0, "R7 x0 reads zero", rd1_data, 32'd0);
    @(negedge clk);
    rd1_en = 1'b0;
    chk(ecc_status == 2'b01, "R7 x0 no report", {30'd0, ecc_status}, 32'd1);

    // R11 disabled port reports nothing
    csr_put(32'h8000_0001);
    reg_put(5'd7, 32'h0000_00F0);
    csr_put(32'd0);
    rd0_en = 1'b0; rd0_addr = 5'd7;
    @(negedge clk);
    chk(ecc_status == 2'b01, "R11 disabled read quiet", {30'd0, ecc_status}, 32'd1);
    chk(!t_trap, "R11 no trap", {31'd0, t_trap}, 32'd0);

    // R10 both ports err together, uncorrectable wins
    rd0_en = 1'b1; rd0_addr = 5'd2;
    rd1_en = 1'b1; rd1_addr = 5'd7;
    #1;
    chk(rd0_data == 32'h1234_5678, "R10 port0 corrected", rd0_data, 32'h1234_5678);
    chk(rd1_data == 32'h0000_00F3, "R10 port1 raw", rd1_data, 32'h0000_00F3);
    @(negedge clk);
    rd0_en = 1'b0; rd1_en = 1'b0;
    chk(ecc_status == 2'b11, "R10 status", {30'd0, ecc_status}, 32'd3);
    chk(t_trap && t_cause == CAUSE, "R9 dual trap", {25'd0, t_trap, t_cause}, {25'd0, 1'b1, CAUSE});
    @(negedge clk);
    chk(!t_trap, "R9 trap one cycle", {31'd0, t_trap}, 32'd0);

    // R6 reset clears status, requests and storage
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd0_en = 1'b1; rd0_addr = 5'd2;
    #1;
    chk(rd0_data == 32'd0, "R6 storage cleared", rd0_data, 32'd0);
    chk(ecc_status == 2'b00 && ecc_source == 4'd0 && !stall_req, "R6 reset clears",
        {25'd0, stall_req, ecc_status, ecc_source}, 32'd0);
    @(negedge clk);
    rd0_en = 1'b0;
    chk(ecc_status == 2'b00, "R2 clean read after reset", {30'd0, ecc_status}, 32'd0);
    fin();
  end
endmodule